// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block is a single-level data translation buffer. It caches virtual-to-physical translations for three page sizes: 4 KB, 2 MB and 1 GB. Each page size has its own fully associative pool of entries, and a parameter sets the capacity of each pool on its own. A pool may be left out entirely by giving it zero entries. The reach of the buffer is the sum of each pool's entry count times its page size. A 2 MB entry covers the same range as 512 consecutive 4 KB pages.

A lookup presents a 48-bit virtual address, and all pools are searched in the same cycle. One cycle later the block returns a hit flag, the physical address and the page size of the entry that hit. A fill installs a translation into the pool chosen by its size code. A flush invalidates every entry in one cycle.

Top module: `mpt_tlb`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `lk_valid` is high, and low otherwise; `rsp_hit`, `rsp_paddr` and `rsp_size` are registered in that same cycle.
- R2: A 4 KB entry matches when virtual bits [47:12] are equal, a 2 MB entry when bits [47:21] are equal, and a 1 GB entry when bits [47:30] are equal. A 2 MB entry therefore hits for every 4 KB-aligned address in its range.
- R3: On a hit, `rsp_paddr` is the stored frame base in the upper bits, with the lookup address's low bits passed through unchanged: 12, 21 or 30 bits for the three sizes.
- R4: `rsp_size` encodes 0 = 4 KB, 1 = 2 MB, 2 = 1 GB. On a miss, `rsp_size` and `rsp_paddr` are zero. Code 3 is never reported.
- R5: A fill goes only to the pool named by `fill_size` (0, 1 or 2), and a fill with code 3 changes nothing.
- R6: Within a pool, a fill writes in this order of preference: the entry whose tag already equals the fill address, then the lowest-numbered invalid entry, then the entry at the round-robin pointer. The pointer advances by one, wrapping, only when it was used. Reset and flush return it to entry 0.
- R7: `flush` clears all entries in one cycle. A lookup in the same cycle as a flush reports a miss, and a fill in the same cycle as a flush is dropped.
- R8: A lookup in the same cycle as a fill sees the contents from before that fill.
- R9: When several pools hit, the smallest page size wins.
- R10: A pool configured with zero entries never hits, and fills aimed at it have no effect.
- R11: After reset, all entries are invalid and every response output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| fill_valid | input | 1 | Fill request |
| fill_size | input | 2 | Fill page size code |
| fill_vaddr | input | VA_W | Fill virtual address (page aligned bits used) |
| fill_paddr | input | PA_W | Fill physical frame base |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_size | output | 2 | Page size of the hit entry |

## Verification
Lookups are made one page past each entry and with only bit 47 changed, so that wrong tag widths are caught. Lookups at the first and last byte of each page show whether the offset passes through correctly. A sweep over all 512 4 KB-aligned addresses of one 2 MB page separates a correct 21-bit offset from narrower ones. An overlapping 4 KB entry inside that page shows the priority between pools. Filling the 4 KB pool past its capacity, after an overwrite of an existing tag, shows which entry each fill replaces. Flush, and fills and lookups that share a cycle with other operations, show the same-cycle ordering. A second instance with no 1 GB pool covers the empty-pool case.

// File: rtl/mpt_pkg.sv
`timescale 1ns/1ps
package mpt_pkg;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_2M   = 2'd1,
        PG_1G   = 2'd2,
        PG_RSVD = 2'd3
    } pg_size_e;

    // untranslated low bits for size class k: 12, 21, 30
    function automatic int page_off(input int k);
        return 12 + 9 * k;
    endfunction
endpackage

// File: rtl/mpt_victim.sv
`timescale 1ns/1ps
module mpt_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] match,
    input  logic [IDX_W-1:0]   rr,
    output logic [IDX_W-1:0]   idx,
    output logic               from_rr
);
    always_comb begin
        idx     = rr;
        from_rr = 1'b1;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                idx     = IDX_W'(i);
                from_rr = 1'b0;
            end
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx     = IDX_W'(i);
                from_rr = 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpt_pool.sv
`timescale 1ns/1ps
module mpt_pool #(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 48,
    parameter int PA_W    = 48,
    parameter int OFF     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [VA_W-1:0] lk_va,
    input  logic            fill_en,
    input  logic [VA_W-1:0] fill_va,
    input  logic [PA_W-1:0] fill_pa,
    output logic            hit,
    output logic [PA_W-1:0] pa
);
    localparam int TAG_W = VA_W - OFF;
    localparam int FRM_W = PA_W - OFF;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    generate
        if (ENTRIES == 0) begin : g_none
            logic unused_none;
            assign unused_none = ^{clk, rst_n, flush, lk_va, fill_en, fill_va, fill_pa};
            assign hit = 1'b0;
            assign pa  = '0;
        end else begin : g_pool
            logic [ENTRIES-1:0] vld;
            logic [TAG_W-1:0]   tag [ENTRIES];
            logic [FRM_W-1:0]   frm [ENTRIES];
            logic [ENTRIES-1:0] lk_match;
            logic [ENTRIES-1:0] fill_match;
            logic [IDX_W-1:0]   rr_ptr;
            logic [IDX_W-1:0]   victim;
            logic               use_rr;
            logic [FRM_W-1:0]   hit_frm;
            logic               unused_low;

            assign unused_low = ^{fill_va[OFF-1:0], fill_pa[OFF-1:0]};

            for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
                assign lk_match[i]   = vld[i] && (tag[i] == lk_va[VA_W-1:OFF]);
                assign fill_match[i] = vld[i] && (tag[i] == fill_va[VA_W-1:OFF]);
            end

            mpt_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
                .valid   (vld),
                .match   (fill_match),
                .rr      (rr_ptr),
                .idx     (victim),
                .from_rr (use_rr)
            );

            always_comb begin
                hit_frm = '0;
                for (int i = ENTRIES - 1; i >= 0; i--) begin
                    if (lk_match[i]) hit_frm = frm[i];
                end
            end

            assign hit = |lk_match;
            assign pa  = {hit_frm, lk_va[OFF-1:0]};

            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    vld    <= '0;
                    rr_ptr <= '0;
                end else if (fill_en) begin
                    vld[victim] <= 1'b1;
                    if (use_rr) begin
                        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (fill_en && rst_n && !flush) begin
                    tag[victim] <= fill_va[VA_W-1:OFF];
                    frm[victim] <= fill_pa[PA_W-1:OFF];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mpt_tlb.sv
`timescale 1ns/1ps
module mpt_tlb
    import mpt_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 48,
    parameter int E4K  = 8,
    parameter int E2M  = 4,
    parameter int E1G  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_vaddr,
    input  logic            fill_valid,
    input  logic [1:0]      fill_size,
    input  logic [VA_W-1:0] fill_vaddr,
    input  logic [PA_W-1:0] fill_paddr,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_size
);
    logic [NUM_SIZES-1:0] pool_hit;
    logic [NUM_SIZES-1:0] pool_fill;
    logic [PA_W-1:0]      pool_pa [NUM_SIZES];

    generate
        for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
            localparam int ENT = (k == 0) ? E4K : ((k == 1) ? E2M : E1G);
            assign pool_fill[k] = fill_valid && !flush && (fill_size == 2'(k));
            mpt_pool #(
                .ENTRIES (ENT),
                .VA_W    (VA_W),
                .PA_W    (PA_W),
                .OFF     (page_off(k))
            ) u_pool (
                .clk     (clk),
                .rst_n   (rst_n),
                .flush   (flush),
                .lk_va   (lk_vaddr),
                .fill_en (pool_fill[k]),
                .fill_va (fill_vaddr),
                .fill_pa (fill_paddr),
                .hit     (pool_hit[k]),
                .pa      (pool_pa[k])
            );
        end
    endgenerate

    logic            sel_hit;
    logic [PA_W-1:0] sel_pa;
    pg_size_e        sel_size;

    // smallest page size has priority
    always_comb begin
        sel_hit  = 1'b0;
        sel_pa   = '0;
        sel_size = PG_4K;
        for (int k = NUM_SIZES - 1; k >= 0; k--) begin
            if (pool_hit[k]) begin
                sel_hit  = 1'b1;
                sel_pa   = pool_pa[k];
                sel_size = pg_size_e'(2'(k));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_size  <= 2'd0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid && !flush && sel_hit) begin
                rsp_hit   <= 1'b1;
                rsp_paddr <= sel_pa;
                rsp_size  <= sel_size;
            end else begin
                rsp_hit   <= 1'b0;
                rsp_paddr <= '0;
                rsp_size  <= 2'd0;
            end
        end
    end
endmodule

// File: rtl/mpt_tlb_chk.sv
`timescale 1ns/1ps
module mpt_tlb_chk #(
    parameter int VA_W = 48,
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            fill_valid,
    input logic [1:0]      fill_size,
    input logic [VA_W-1:0] fill_vaddr,
    input logic [PA_W-1:0] fill_paddr,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_size
);
    logic unused_chk;
    assign unused_chk = ^{fill_valid, fill_size, fill_vaddr, fill_paddr};

    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r7_flush_lookup_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_valid) |=> !rsp_hit);

    a_r4_miss_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0 && rsp_size == 2'd0));

    a_r4_size_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_size != 2'd3);

    a_r11_hit_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    a_r3_offset_4k: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!(rsp_hit && rsp_size == 2'd0) || rsp_paddr[11:0] == $past(lk_vaddr[11:0])));

    a_r3_offset_2m: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!(rsp_hit && rsp_size == 2'd1) || rsp_paddr[20:0] == $past(lk_vaddr[20:0])));

    a_r3_offset_1g: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!(rsp_hit && rsp_size == 2'd2) || rsp_paddr[29:0] == $past(lk_vaddr[29:0])));
endmodule

bind mpt_tlb mpt_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/test_mpt_tlb.sv
`timescale 1ns/1ps
module test_mpt_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_size = '0;
    logic [47:0] fill_vaddr = '0;
    logic [47:0] fill_paddr = '0;
    logic        rsp_valid, rsp_hit;
    logic [47:0] rsp_paddr;
    logic [1:0]  rsp_size;

    logic        n_rsp_valid, n_rsp_hit;
    logic [47:0] n_rsp_paddr;
    logic [1:0]  n_rsp_size;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    mpt_tlb i_mpt_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_size(fill_size),
        .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_size(rsp_size)
    );

    // same stimulus, no 1 GB pool
    mpt_tlb #(.E1G(0)) i_mpt_tlb_nogb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_size(fill_size),
        .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
        .rsp_valid(n_rsp_valid), .rsp_hit(n_rsp_hit),
        .rsp_paddr(n_rsp_paddr), .rsp_size(n_rsp_size)
    );

    typedef struct packed {
        logic [47:0] va;
        logic        hit;
        logic [47:0] pa;
        logic [1:0]  sz;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{48'h0000_1234_5ABC, 1'b1, 48'h0000_00AB_CABC, 2'd0},
        '{48'h0000_1234_6000, 1'b0, 48'h0,              2'd0},
        '{48'h0000_4060_0000, 1'b1, 48'h0000_0120_0000, 2'd1},
        '{48'h0000_407F_FFF8, 1'b1, 48'h0000_013F_FFF8, 2'd1},
        '{48'h0000_4080_0000, 1'b0, 48'h0,              2'd0},
        '{48'h0012_8000_0010, 1'b1, 48'h0000_C000_0010, 2'd2},
        '{48'h0012_BFFF_FFFF, 1'b1, 48'h0000_FFFF_FFFF, 2'd2},
        '{48'h0012_C000_0000, 1'b0, 48'h0,              2'd0},
        '{48'h8000_1234_5000, 1'b0, 48'h0,              2'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [47:0] va);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic [47:0] pa, input logic [1:0] sz);
        chk(rsp_valid && rsp_hit == hit && rsp_paddr == pa && rsp_size == sz, req,
            {13'd0, rsp_valid, rsp_hit, rsp_size, rsp_paddr},
            {13'd0, 1'b1, hit, sz, pa});
    endtask

    task automatic fill(input logic [1:0] sz, input logic [47:0] va, input logic [47:0] pa);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_size  = sz;
        fill_vaddr = va;
        fill_paddr = pa;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!rsp_valid && !rsp_hit && rsp_paddr == 0 && rsp_size == 0, "R11 reset outputs",
            {rsp_valid, rsp_hit, rsp_size, rsp_paddr}, 64'h0);
        rst_n = 1'b1;
        lookup(48'h0000_1234_5000);
        expect_rsp("R11 empty after reset", 1'b0, 48'h0, 2'd0);
        // R1: strobe drops after one cycle
        @(negedge clk);
        chk(!rsp_valid, "R1 single response", rsp_valid, 0);

        fill(2'd0, 48'h0000_1234_5000, 48'h0000_00AB_C000);
        fill(2'd1, 48'h0000_4060_0000, 48'h0000_0120_0000);
        fill(2'd2, 48'h0012_8000_0000, 48'h0000_C000_0000);

        // R2 R3 R4: vector table
        for (int v = 0; v < NVEC; v++) begin
            lookup(VEC[v].va);
            expect_rsp("R2/R3/R4 table", VEC[v].hit, VEC[v].pa, VEC[v].sz);
        end

        // R2: every 4 KB-aligned address of the 2 MB page
        for (int i = 0; i < 512; i++) begin
            lookup(48'h0000_4060_0007 + 48'(i) * 48'h1000);
            expect_rsp("R2 2M sweep", 1'b1, 48'h0000_0120_0007 + 48'(i) * 48'h1000, 2'd1);
        end

        // R9: overlapping 4 KB entry wins (4K idx1)
        fill(2'd0, 48'h0000_4060_3000, 48'h0000_0555_5000);
        lookup(48'h0000_4060_3010);
        expect_rsp("R9 small page wins", 1'b1, 48'h0000_0555_5010, 2'd0);
        lookup(48'h0000_4060_4010);
        expect_rsp("R9 neighbour uses 2M", 1'b1, 48'h0000_0120_4010, 2'd1);

        // R8: lookup in the fill cycle sees old contents (4K idx2)
        @(negedge clk);
        fill_valid = 1'b1; fill_size = 2'd0;
        fill_vaddr = 48'h0000_0100_2000; fill_paddr = 48'h0000_0A00_2000;
        lk_valid = 1'b1; lk_vaddr = 48'h0000_0100_2000;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        expect_rsp("R8 fill not yet visible", 1'b0, 48'h0, 2'd0);
        lookup(48'h0000_0100_2000);
        expect_rsp("R8 fill visible next", 1'b1, 48'h0000_0A00_2000, 2'd0);

        // R6: refill of existing tag overwrites idx0
        fill(2'd0, 48'h0000_1234_5000, 48'h0000_0DDD_D000);
        lookup(48'h0000_1234_5004);
        expect_rsp("R6 overwrite same tag", 1'b1, 48'h0000_0DDD_D004, 2'd0);
        for (int k = 3; k < 8; k++)
            fill(2'd0, 48'h0000_0100_0000 + 48'(k) * 48'h1000, 48'h0000_0A00_0000 + 48'(k) * 48'h1000);
        lookup(48'h0000_0100_7000);
        expect_rsp("R6 pool full", 1'b1, 48'h0000_0A00_7000, 2'd0);
        // full: victim idx0 then idx1
        fill(2'd0, 48'h0000_0200_0000, 48'h0000_0B00_0000);
        lookup(48'h0000_1234_5000);
        expect_rsp("R6 rr evicts entry0", 1'b0, 48'h0, 2'd0);
        lookup(48'h0000_0200_0010);
        expect_rsp("R6 new entry hits", 1'b1, 48'h0000_0B00_0010, 2'd0);
        lookup(48'h0000_4060_3010);
        expect_rsp("R6 entry1 survives", 1'b1, 48'h0000_0555_5010, 2'd0);
        fill(2'd0, 48'h0000_0300_0000, 48'h0000_0C00_0000);
        lookup(48'h0000_4060_3010);
        expect_rsp("R6 rr evicts entry1", 1'b1, 48'h0000_0120_3010, 2'd1);
        lookup(48'h0000_0100_3000);
        expect_rsp("R6 entry3 survives", 1'b1, 48'h0000_0A00_3000, 2'd0);

        // R5: size code routing
        fill(2'd3, 48'h0000_0500_0000, 48'h0000_0D00_0000);
        lookup(48'h0000_0500_0000);
        expect_rsp("R5 code 3 ignored", 1'b0, 48'h0, 2'd0);
        fill(2'd0, 48'h0000_0600_0000, 48'h0000_0E00_0000);
        lookup(48'h0000_0600_1000);
        expect_rsp("R5 4K fill not 2M", 1'b0, 48'h0, 2'd0);

        // R10: no 1 GB pool in second instance
        fill(2'd2, 48'h0040_0000_0000, 48'h0000_4000_0000);
        lookup(48'h0040_0000_0100);
        chk(n_rsp_valid && !n_rsp_hit && n_rsp_paddr == 0, "R10 empty pool misses",
            {n_rsp_hit, n_rsp_paddr}, 64'h0);
        expect_rsp("R10 full instance hits", 1'b1, 48'h0000_4000_0100, 2'd2);
        lookup(48'h0000_4060_0000);
        chk(n_rsp_hit && n_rsp_size == 2'd1 && n_rsp_paddr == 48'h0000_0120_0000, "R10 other pools work",
            {n_rsp_hit, n_rsp_size, n_rsp_paddr}, {1'b1, 2'd1, 48'h0000_0120_0000});

        // R7: flush with lookup and fill in the same cycle
        @(negedge clk);
        flush = 1'b1; lk_valid = 1'b1; lk_vaddr = 48'h0000_4060_0000;
        fill_valid = 1'b1; fill_size = 2'd1;
        fill_vaddr = 48'h0000_8000_0000; fill_paddr = 48'h0000_0200_0000;
        @(negedge clk);
        flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
        expect_rsp("R7 lookup in flush cycle", 1'b0, 48'h0, 2'd0);
        lookup(48'h0012_8000_0000);
        expect_rsp("R7 1G cleared", 1'b0, 48'h0, 2'd0);
        lookup(48'h0000_0100_3000);
        expect_rsp("R7 4K cleared", 1'b0, 48'h0, 2'd0);
        lookup(48'h0000_8000_0000);
        expect_rsp("R7 fill dropped", 1'b0, 48'h0, 2'd0);
        fill(2'd1, 48'h0000_8000_0000, 48'h0000_0200_0000);
        lookup(48'h0000_8010_0000);
        expect_rsp("R7 fill after flush", 1'b1, 48'h0000_0210_0000, 2'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule